// File: doc/BRIEF.md
# Shared Burst Command Arbiter

This block lets four independent requesters share one memory command port of the kind used by synchronous DRAM. A requester raises its request line and presents a direction, a bank, a row and a start column. The arbiter picks one requester and grants it the port for one complete burst. During that burst it opens the row, issues a single read or write command for a fixed burst of data beats, and closes the row again with a precharge. Because every access closes its row, no bank state carries over from one grant to the next.

The arbiter also refreshes the memory on its own. An interval counter raises a pending refresh. At the next arbitration point that refresh wins over every client, but it never interrupts a burst already in progress. Client arbitration is either fixed priority or round robin, chosen by a mode input. All waits between commands come from timing parameters, and the command output shows no-op on every wait cycle.

Top module: `burst_arbiter`

## Requirements
- R1: While reset is asserted, and right after it, `gnt_o` and `done_o` are all zero and `cmd_o` is NOP. The command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5.
- R2: A granted burst runs in this order:
  - ACT, with the row on `addr_o` and the bank on `bank_o`.
  - Exactly T_RCD cycles after ACT, one RD (when the client's `dir_i` bit is 0) or one WR (when the bit is 1), with the start column on `addr_o`.
  - PRE on the same bank, BURST_LEN+T_CL+1 cycles after RD or BURST_LEN+T_WR+1 cycles after WR.
  - NOP on every cycle in between.
- R3: `gnt_o` is one-hot and is held from the ACT cycle through the done cycle, then clears. `done_o` pulses for one cycle on the granted client's bit, T_RP cycles after PRE.
- R4: In fixed mode (`rr_mode_i`=0), the lowest-numbered requesting client wins, whatever clients were served before.
- R5: In round-robin mode (`rr_mode_i`=1), the search starts at the client after the one served last, so the client served last has the lowest priority. After reset the search starts at client 0.
- R6: The refresh counter is loaded with its full interval at reset. A refresh falls due every REF_INT cycles. On an idle port the first REF appears REF_INT+1 cycles after reset is released, and the following ones come REF_INT cycles apart. After a REF the port stays idle for T_RFC NOP cycles plus one arbitration cycle, so the next ACT comes T_RFC+2 cycles after the REF.
- R7: A pending refresh wins over every waiting client at the next arbitration point. REF is never issued while a grant is active.
- R8: When a client is waiting, the next ACT follows a done pulse by exactly 2 cycles, one of which is the arbitration cycle.
- R9: Direction, bank, row and column are captured in the arbitration cycle. Changing them after the grant does not affect the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rr_mode_i | input | 1 | 1 selects round robin, 0 selects fixed priority |
| req_i | input | 4 | Per-client burst request |
| dir_i | input | 4 | Per-client direction, 1 = write |
| bank_i | input | 8 | Per-client bank, client k at bits [2k+1:2k] |
| row_i | input | 52 | Per-client row, 13 bits per client |
| col_i | input | 40 | Per-client start column, 10 bits per client |
| gnt_o | output | 4 | One-hot grant, held for the whole access |
| done_o | output | 4 | One-cycle completion pulse |
| cmd_o | output | 3 | Command code |
| bank_o | output | 2 | Command bank |
| addr_o | output | 13 | Row or column address |

## Verification
The test patterns are:
- **Single requests of each direction.** These separate the read wait from the write wait and show that the row and column are taken from the right client.
- **All four clients requesting at once, in both modes.** This separates fixed priority from round robin. One round-robin run starts right after reset and one starts where the client served last is client 2, so the expected orders are 0,1,2,3 and 3,0,1,2.
- **Two clients after the round-robin pointer has moved.** This checks that fixed mode ignores service history.
- **An idle stretch.** This measures the refresh period.
- **A request timed so that a refresh falls due in the middle of a burst.** This shows that the refresh waits for the burst to finish and then goes ahead of the client still waiting.

// File: rtl/burst_arb_pkg.sv
`timescale 1ns/1ps
package burst_arb_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ACT, S_TRCD, S_RW, S_DATA, S_PRE, S_TRP, S_REF, S_TRFC
  } seq_state_e;
endpackage

// File: rtl/burst_arb_pick.sv
`timescale 1ns/1ps
module burst_arb_pick #(
  parameter int N_CLI = 4,
  parameter int IW    = $clog2(N_CLI)
) (
  input  logic [N_CLI-1:0] req_i,
  input  logic             rr_i,
  input  logic [IW-1:0]    ptr_i,
  output logic             any_o,
  output logic [IW-1:0]    win_o
);
  // Scan from the lowest priority down so the highest-priority hit is written last.
  always_comb begin : p_pick
    int idx;
    any_o = |req_i;
    win_o = '0;
    for (int k = N_CLI - 1; k >= 0; k--) begin
      idx = rr_i ? ((int'(ptr_i) + k) % N_CLI) : k;
      if (req_i[idx]) win_o = IW'(idx);
    end
  end
endmodule

// File: rtl/burst_arb_refresh.sv
`timescale 1ns/1ps
module burst_arb_refresh #(
  parameter int REF_INT = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic pend_o
);
  localparam int CW = $clog2(REF_INT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(REF_INT - 1);
      pend_o <= 1'b0;
    end else begin
      if (cnt_q == '0) cnt_q <= CW'(REF_INT - 1);
      else             cnt_q <= cnt_q - 1'b1;
      if (cnt_q == '0) pend_o <= 1'b1;
      else if (clr_i)  pend_o <= 1'b0;
    end
  end

  assert_pend_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o);
endmodule

// File: rtl/burst_arb_seq.sv
`timescale 1ns/1ps
module burst_arb_seq
  import burst_arb_pkg::*;
#(
  parameter int N_CLI     = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int BURST_LEN = 8,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int T_CL      = 3,
  parameter int T_RFC     = 8,
  localparam int IW       = $clog2(N_CLI),
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rr_i,
  input  logic [N_CLI-1:0]        req_i,
  input  logic [N_CLI-1:0]        dir_i,
  input  logic [N_CLI*BANK_W-1:0] bank_i,
  input  logic [N_CLI*ROW_W-1:0]  row_i,
  input  logic [N_CLI*COL_W-1:0]  col_i,
  input  logic                    ref_pend_i,
  output logic                    ref_clr_o,
  output logic [N_CLI-1:0]        gnt_o,
  output logic [N_CLI-1:0]        done_o,
  output logic [2:0]              cmd_o,
  output logic [BANK_W-1:0]       bank_o,
  output logic [ADDR_W-1:0]       addr_o
);
  localparam int WR_WAIT = BURST_LEN + T_WR;
  localparam int RD_WAIT = BURST_LEN + T_CL;
  localparam int W_A     = (WR_WAIT > RD_WAIT) ? WR_WAIT : RD_WAIT;
  localparam int W_B     = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int W_MAX   = ((W_A > W_B) ? W_A : W_B) + T_RCD;
  localparam int CNT_W   = $clog2(W_MAX + 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IW-1:0]     ptr_q;
  logic              dir_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              any;
  logic [IW-1:0]     win;
  logic              cnt_zero;
  cmd_e              cmd;

  burst_arb_pick #(.N_CLI(N_CLI)) u_pick (
    .req_i(req_i), .rr_i(rr_i), .ptr_i(ptr_q), .any_o(any), .win_o(win)
  );

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      ptr_q   <= '0;
      gnt_o   <= '0;
      dir_q   <= 1'b0;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (ref_pend_i) begin
            state_q <= S_REF;
          end else if (any) begin
            state_q <= S_ACT;
            gnt_o   <= N_CLI'(1) << win;
            ptr_q   <= (int'(win) == N_CLI - 1) ? '0 : win + 1'b1;
            dir_q   <= dir_i[win];
            bank_q  <= bank_i[win*BANK_W +: BANK_W];
            row_q   <= row_i[win*ROW_W +: ROW_W];
            col_q   <= col_i[win*COL_W +: COL_W];
          end
        end
        S_ACT: begin
          cnt_q   <= CNT_W'(T_RCD - 2);
          state_q <= S_TRCD;
        end
        S_TRCD: begin
          if (cnt_zero) state_q <= S_RW;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        S_RW: begin
          cnt_q   <= dir_q ? CNT_W'(WR_WAIT - 1) : CNT_W'(RD_WAIT - 1);
          state_q <= S_DATA;
        end
        S_DATA: begin
          if (cnt_zero) state_q <= S_PRE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        S_PRE: begin
          cnt_q   <= CNT_W'(T_RP - 1);
          state_q <= S_TRP;
        end
        S_TRP: begin
          if (cnt_zero) begin
            state_q <= S_IDLE;
            gnt_o   <= '0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_REF: begin
          cnt_q   <= CNT_W'(T_RFC - 1);
          state_q <= S_TRFC;
        end
        S_TRFC: begin
          if (cnt_zero) state_q <= S_IDLE;
          else          cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd    = CMD_NOP;
    bank_o = '0;
    addr_o = '0;
    case (state_q)
      S_ACT: begin cmd = CMD_ACT; bank_o = bank_q; addr_o = ADDR_W'(row_q); end
      S_RW:  begin cmd = dir_q ? CMD_WR : CMD_RD; bank_o = bank_q; addr_o = ADDR_W'(col_q); end
      S_PRE: begin cmd = CMD_PRE; bank_o = bank_q; end
      S_REF: cmd = CMD_REF;
      default: ;
    endcase
  end

  assign cmd_o     = cmd;
  assign ref_clr_o = (state_q == S_REF);
  assign done_o    = (state_q == S_TRP && cnt_zero) ? gnt_o : '0;

  assert_gnt_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_gnt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && done_o == '0) |=> $stable(gnt_o));
  assert_gnt_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o != '0) |=> (gnt_o == '0));
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o != '0) |=> (done_o == '0));
  assert_done_owner_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o != '0) |-> (done_o == gnt_o));
  assert_act_then_nop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |=> (cmd_o == CMD_NOP));
  assert_ref_no_gnt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF) |-> (gnt_o == '0));
  assert_ref_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && ref_pend_i) |=> (cmd_o == CMD_REF));
  assert_win_requests_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any |-> req_i[win]);
  assert_rr_ptr_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr_i && req_i[ptr_q]) |-> (win == ptr_q));
endmodule

// File: rtl/burst_arbiter.sv
`timescale 1ns/1ps
module burst_arbiter #(
  parameter int N_CLI     = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int BURST_LEN = 8,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int T_CL      = 3,
  parameter int T_RFC     = 8,
  parameter int REF_INT   = 780,
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rr_mode_i,
  input  logic [N_CLI-1:0]        req_i,
  input  logic [N_CLI-1:0]        dir_i,
  input  logic [N_CLI*BANK_W-1:0] bank_i,
  input  logic [N_CLI*ROW_W-1:0]  row_i,
  input  logic [N_CLI*COL_W-1:0]  col_i,
  output logic [N_CLI-1:0]        gnt_o,
  output logic [N_CLI-1:0]        done_o,
  output logic [2:0]              cmd_o,
  output logic [BANK_W-1:0]       bank_o,
  output logic [ADDR_W-1:0]       addr_o
);
  logic ref_pend;
  logic ref_clr;

  burst_arb_refresh #(.REF_INT(REF_INT)) u_refresh (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(ref_clr), .pend_o(ref_pend)
  );

  burst_arb_seq #(
    .N_CLI(N_CLI), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .BURST_LEN(BURST_LEN), .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR),
    .T_CL(T_CL), .T_RFC(T_RFC)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .rr_i(rr_mode_i), .req_i(req_i),
    .dir_i(dir_i), .bank_i(bank_i), .row_i(row_i), .col_i(col_i),
    .ref_pend_i(ref_pend), .ref_clr_o(ref_clr), .gnt_o(gnt_o),
    .done_o(done_o), .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o)
  );
endmodule

// File: tb/burst_arbiter_bench.sv
`timescale 1ns/1ps
module burst_arbiter_bench;
  localparam int N = 4, BW = 2, RW = 13, CW = 10, BL = 8;
  localparam int TRCD = 3, TRP = 3, TWR = 2, TCL = 3, TRFC = 8, RINT = 400;
  localparam int AW = (RW > CW) ? RW : CW;

  typedef struct {
    int    cmd;
    int    bank;
    int    addr;
    int    gnt;
    int    gap;
    string tag;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rr_mode = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] dir = '0;
  logic [N*BW-1:0] bank_f = '0;
  logic [N*RW-1:0] row_f = '0;
  logic [N*CW-1:0] col_f = '0;
  logic [N-1:0] gnt, done;
  logic [2:0] cmd;
  logic [BW-1:0] bank;
  logic [AW-1:0] addr;

  int tests = 0, fails = 0, cyc = 0, last_cyc = 0, m_ptr = 0;
  bit last_bg = 1'b0, finished = 1'b0;
  ev_t q[$];
  int ref_log[$];
  int m_dir[N], m_bank[N], m_row[N], m_col[N];

  always #10 clk = ~clk;

  burst_arbiter #(
    .N_CLI(N), .BANK_W(BW), .ROW_W(RW), .COL_W(CW), .BURST_LEN(BL),
    .T_RCD(TRCD), .T_RP(TRP), .T_WR(TWR), .T_CL(TCL), .T_RFC(TRFC), .REF_INT(RINT)
  ) u_burst_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .rr_mode_i(rr_mode), .req_i(req), .dir_i(dir),
    .bank_i(bank_f), .row_i(row_f), .col_i(col_f), .gnt_o(gnt), .done_o(done),
    .cmd_o(cmd), .bank_o(bank), .addr_o(addr)
  );

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Requesters drop their request once granted.
  always @(negedge clk)
    for (int i = 0; i < N; i++) if (gnt[i]) req[i] <= 1'b0;

  task automatic on_event(int c, int bk, int ad, int g);
    ev_t e;
    if (c == 5 && (q.size() == 0 || q[0].cmd != 5)) begin
      ref_log.push_back(cyc);
      chk(g == 0, "R7", "grant during refresh", g, 0);
      last_cyc = cyc;
      last_bg  = 1'b1;
      return;
    end
    if (q.size() == 0) begin
      chk(1'b0, "R2", "unexpected command", c, -1);
      last_cyc = cyc;
      return;
    end
    e = q.pop_front();
    chk(c == e.cmd, e.tag, "command", c, e.cmd);
    chk(g == e.gnt, e.tag, "grant", g, e.gnt);
    if (e.cmd >= 1 && e.cmd <= 3) chk(ad == e.addr, e.tag, "address", ad, e.addr);
    if (e.cmd >= 1 && e.cmd <= 4) chk(bk == e.bank, e.tag, "bank", bk, e.bank);
    if (e.gap >= 0 && !last_bg) chk(cyc - last_cyc == e.gap, e.tag, "cycle gap", cyc - last_cyc, e.gap);
    last_cyc = cyc;
    last_bg  = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd != 3'd0) on_event(int'(cmd), int'(bank), int'(addr), int'(gnt));
      if (done != '0) on_event(6, 0, 0, int'(done));
    end
  end

  task automatic push(int c, int b, int a, int g, int gap, string tag);
    ev_t e;
    e.cmd = c; e.bank = b; e.addr = a; e.gnt = g; e.gap = gap; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic set_client(int c, int d, int b, int r, int co);
    dir[c] = d[0];
    bank_f[c*BW +: BW] = BW'(b);
    row_f[c*RW +: RW] = RW'(r);
    col_f[c*CW +: CW] = CW'(co);
    m_dir[c] = d; m_bank[c] = b; m_row[c] = r; m_col[c] = co;
  endtask

  task automatic push_burst(int c, int first_gap, string tag);
    int g = 1 << c;
    push(1, m_bank[c], m_row[c], g, first_gap, tag);
    push(m_dir[c] != 0 ? 3 : 2, m_bank[c], m_col[c], g, TRCD, "R2");
    push(4, m_bank[c], 0, g, BL + (m_dir[c] != 0 ? TWR : TCL) + 1, "R2");
    push(6, 0, 0, g, TRP, "R3");
    m_ptr = (c + 1) % N;
  endtask

  function automatic int pick(int p, bit rr);
    for (int k = 0; k < N; k++) begin
      int idx = rr ? (m_ptr + k) % N : k;
      if (p[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic serve(int p, bit rr, string tag);
    bit first = 1'b1;
    while (p != 0) begin
      int c = pick(p, rr);
      push_burst(c, first ? -1 : 2, first ? tag : "R8");
      p &= ~(1 << c);
      first = 1'b0;
    end
  endtask

  task automatic drain(string rq);
    for (int i = 0; i < 600 && q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, rq, "expected events left", q.size(), 0);
    q.delete();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int target, m, r1;
    for (int i = 0; i < N; i++) set_client(i, i % 2, i, 100 + 37 * i, 8 * i + 3);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(gnt == '0, "R1", "grant in reset", int'(gnt), 0);
    chk(done == '0, "R1", "done in reset", int'(done), 0);
    chk(cmd == 3'd0, "R1", "command in reset", int'(cmd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gnt == '0 && cmd == 3'd0, "R1", "output after reset", int'(cmd), 0);

    // R6 refresh cadence on an idle port
    for (int i = 0; i < 3 * RINT && ref_log.size() < 2; i++) @(negedge clk);
    chk(ref_log.size() >= 2, "R6", "refresh count", ref_log.size(), 2);
    if (ref_log.size() >= 2) begin
      chk(ref_log[0] == RINT + 1, "R6", "first refresh cycle", ref_log[0], RINT + 1);
      chk(ref_log[1] - ref_log[0] == RINT, "R6", "refresh period", ref_log[1] - ref_log[0], RINT);
    end
    r1 = (ref_log.size() > 0) ? ref_log[0] : RINT + 1;
    repeat (TRFC + 4) @(negedge clk);

    // R5 round robin from reset pointer: 0,1,2,3
    rr_mode = 1'b1;
    req = 4'hF;
    serve(15, 1'b1, "R5");
    drain("R5");

    // R9 attributes captured at arbitration, write path
    rr_mode = 1'b0;
    set_client(2, 1, 3, 4000, 517);
    req[2] = 1'b1;
    serve(4, 1'b0, "R9");
    while (!gnt[2]) @(negedge clk);
    row_f[2*RW +: RW] = RW'(11);
    col_f[2*CW +: CW] = CW'(22);
    bank_f[2*BW +: BW] = BW'(0);
    dir[2] = 1'b0;
    drain("R9");
    set_client(2, 0, 2, 174, 19);

    // R2 single read
    req[0] = 1'b1;
    serve(1, 1'b0, "R2");
    drain("R2");

    // R4 fixed priority, all four
    req = 4'hF;
    serve(15, 1'b0, "R4");
    drain("R4");

    // R5 rotation: serve 2, then all four gives 3,0,1,2
    rr_mode = 1'b1;
    req[2] = 1'b1;
    serve(4, 1'b1, "R5");
    drain("R5");
    req = 4'hF;
    serve(15, 1'b1, "R5");
    drain("R5");

    // R4 fixed ignores history (pointer now at 3)
    rr_mode = 1'b0;
    req = 4'b1010;
    serve(10, 1'b0, "R4");
    drain("R4");

    // R7 refresh falls due mid-burst, then goes ahead of the waiting client
    m = 1;
    target = r1 + m * RINT - 6;
    while (target <= cyc + 5) begin m++; target = r1 + m * RINT - 6; end
    while (cyc < target) @(negedge clk);
    req = 4'b0110;
    push_burst(1, -1, "R7");
    push(5, 0, 0, 0, 2, "R7");
    push_burst(2, TRFC + 2, "R6");
    drain("R7");

    summary();
  end
endmodule